// File: doc/BRIEF.md
# Flash Page Program-Verify Sequencer

This block is the control state machine behind one page-program operation on an on-chip flash array. A one-cycle start strobe opens the operation. The block then steps the array's control bits through a fixed sequence: write enable, program setup, program pulse and program verify. Every step is separated by a delay that is a parameter counted in clock cycles. A separate data engine moves the page contents and compares them. It is told when to load the page latches, when to issue the dummy write and when to read verify data. It answers with one flag that says whether any bit still needs another pulse.

Each program pulse sits inside a fixed subroutine. The watchdog enable is raised only for the length of that subroutine. The pulse width is picked from the attempt number: a shorter width for the early attempts and a longer one after them. During the early attempts, each verify is followed by an extra short pulse that fixes the cells in place. The block repeats attempts until verify passes or the attempt limit is used up. It then ends with a single-cycle done or fail flag.

Top module: `fpv_seq`

## Requirements
- R1: Out of reset and while idle, every output is low. A start strobe in idle raises the write enable on the next cycle, and it stays high alone for X_CYC cycles before the first page-load strobe.
- R2: Each pulse subroutine runs in this order: page-load strobe for 1 cycle, then watchdog alone for 1 cycle, then setup for Y_CYC cycles, then setup with program for the pulse width, then setup for A_CYC cycles, then watchdog alone for B_CYC cycles.
- R3: For a main pass, the program bit is high for Z1_CYC cycles on attempts 1 to SHORT_TRY and for Z2_CYC cycles on later attempts.
- R4: After a main pulse, verify is raised for G_CYC cycles, then the dummy-write strobe is high for 1 cycle, then verify is held for E_CYC cycles, then the read strobe is high for 1 cycle. The mismatch input is sampled in that read cycle.
- R5: After the read cycle, verify drops and only the write enable stays high for H_CYC cycles.
- R6: While the attempt number is at most SHORT_TRY, each verify is followed by an extra pass of the same subroutine with a Z3_CYC pulse. The extra-pass output is high from its load strobe to its last watchdog cycle.
- R7: If the last sampled mismatch is 0 when a pass ends, the write enable drops. After T_CYC cycles with all outputs low, done is high for exactly 1 cycle.
- R8: If the mismatch is 1, a new attempt starts at once with a page-load strobe. If attempt MAX_TRY also mismatches, the write enable drops. After T_CYC cycles with all outputs low, fail is high for exactly 1 cycle.
- R9: A start strobe has no effect unless the block is idle. This includes a start in the done or fail cycle.
- R10: The watchdog enable is high only inside a pulse subroutine, never with verify or page-load, and always together with the write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to program one page |
| mismatch_i | input | 1 | From data engine: some bit still needs programming |
| swe_o | output | 1 | Array write enable |
| psu_o | output | 1 | Program setup bit |
| prg_o | output | 1 | Program pulse bit |
| pv_o | output | 1 | Program verify bit |
| wdt_en_o | output | 1 | Watchdog enable around each pulse |
| load_o | output | 1 | Strobe: write page latches from RAM buffer |
| addl_o | output | 1 | Current pass is the extra short-pulse pass |
| dummy_wr_o | output | 1 | Strobe: all-ones dummy write to verify address |
| vread_o | output | 1 | Strobe: read verify data, mismatch sampled |
| done_o | output | 1 | One-cycle success flag |
| fail_o | output | 1 | One-cycle failure flag |

## Verification
A start strobe can arrive in the same cycle as the one-cycle done or fail flag, while the machine is still busy. The bench raises start exactly in the cycle where it sees done or fail, and again in the middle of an operation. The idle period that follows must show no write-enable edge, and no unexpected output segment may reach the scoreboard. Every output change is matched, with its duration, against a timeline worked out from the attempt number and the planned mismatch answers.

// File: rtl/fpv_pkg.sv
package fpv_pkg;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_SWEW,
    ST_LOAD,
    ST_WDT,
    ST_SETUP,
    ST_PULSE,
    ST_HOLDA,
    ST_HOLDB,
    ST_VSET,
    ST_VDUM,
    ST_VSETTLE,
    ST_VREAD,
    ST_VEXIT,
    ST_ENDW,
    ST_DONE,
    ST_FAILW,
    ST_FAIL
  } fpv_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpv_timer.sv
module fpv_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? val_i : (cnt_q - CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fpv_attempts.sv
module fpv_attempts #(
  parameter int unsigned NW        = 10,
  parameter int unsigned SHORT_TRY = 6,
  parameter int unsigned MAX_TRY   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic short_o,
  output logic last_o
);
  logic [NW-1:0] n_q;
  logic [NW-1:0] n_d;
  logic          n_en;

  always_comb begin
    n_en = clr_i || inc_i;
    n_d  = clr_i ? NW'(1) : (n_q + NW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) n_q <= NW'(1);
    else if (n_en) n_q <= n_d;
  end

  assign short_o = (n_q <= NW'(SHORT_TRY));
  assign last_o  = (n_q >= NW'(MAX_TRY));
endmodule

// File: rtl/fpv_width_sel.sv
module fpv_width_sel #(
  parameter int unsigned CW     = 8,
  parameter int unsigned Z1_CYC = 4,
  parameter int unsigned Z2_CYC = 8,
  parameter int unsigned Z3_CYC = 2
) (
  input  logic          short_i,
  input  logic          addl_i,
  output logic [CW-1:0] width_o
);
  always_comb begin
    if (addl_i)       width_o = CW'(Z3_CYC);
    else if (short_i) width_o = CW'(Z1_CYC);
    else              width_o = CW'(Z2_CYC);
  end
endmodule

// File: rtl/fpv_seq.sv
module fpv_seq
  import fpv_pkg::*;
#(
  parameter int unsigned X_CYC     = 20,
  parameter int unsigned Y_CYC     = 50,
  parameter int unsigned Z1_CYC    = 30,
  parameter int unsigned Z2_CYC    = 200,
  parameter int unsigned Z3_CYC    = 10,
  parameter int unsigned A_CYC     = 5,
  parameter int unsigned B_CYC     = 5,
  parameter int unsigned G_CYC     = 4,
  parameter int unsigned E_CYC     = 2,
  parameter int unsigned H_CYC     = 2,
  parameter int unsigned T_CYC     = 20,
  parameter int unsigned SHORT_TRY = 6,
  parameter int unsigned MAX_TRY   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic mismatch_i,
  output logic swe_o,
  output logic psu_o,
  output logic prg_o,
  output logic pv_o,
  output logic wdt_en_o,
  output logic load_o,
  output logic addl_o,
  output logic dummy_wr_o,
  output logic vread_o,
  output logic done_o,
  output logic fail_o
);
  localparam int unsigned MAXD = umax(umax(umax(umax(X_CYC, Y_CYC), umax(Z1_CYC, Z2_CYC)),
                                           umax(umax(Z3_CYC, A_CYC), umax(B_CYC, G_CYC))),
                                      umax(umax(E_CYC, H_CYC), T_CYC));
  localparam int unsigned CW = $clog2(MAXD + 1);
  localparam int unsigned NW = $clog2(MAX_TRY + 2);

  fpv_state_e    state_q, state_d;
  logic          addl_q, addl_d, addl_en;
  logic          miss_q, miss_en;
  logic          tmr_zero, tmr_load;
  logic [CW-1:0] tmr_val, dur, width;
  logic          try_clr, try_inc, try_short, try_last;
  logic          retry;
  fpv_state_e    dec_state;

  fpv_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  fpv_attempts #(.NW(NW), .SHORT_TRY(SHORT_TRY), .MAX_TRY(MAX_TRY)) u_tries (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (try_clr),
    .inc_i   (try_inc),
    .short_o (try_short),
    .last_o  (try_last)
  );

  fpv_width_sel #(.CW(CW), .Z1_CYC(Z1_CYC), .Z2_CYC(Z2_CYC), .Z3_CYC(Z3_CYC)) u_width (
    .short_i (try_short),
    .addl_i  (addl_q),
    .width_o (width)
  );

  // outcome of a finished pass, based on the sampled mismatch
  always_comb begin
    retry = miss_q && !try_last;
    if (!miss_q)       dec_state = ST_ENDW;
    else if (try_last) dec_state = ST_FAILW;
    else               dec_state = ST_LOAD;
  end

  // next state
  always_comb begin
    state_d = state_q;
    try_clr = 1'b0;
    try_inc = 1'b0;
    addl_en = 1'b0;
    addl_d  = 1'b0;
    miss_en = 1'b0;
    if (state_q == ST_IDLE) begin
      if (start_i) begin
        state_d = ST_SWEW;
        try_clr = 1'b1;
        addl_en = 1'b1;
      end
    end else if (tmr_zero) begin
      case (state_q)
        ST_SWEW:    state_d = ST_LOAD;
        ST_LOAD:    state_d = ST_WDT;
        ST_WDT:     state_d = ST_SETUP;
        ST_SETUP:   state_d = ST_PULSE;
        ST_PULSE:   state_d = ST_HOLDA;
        ST_HOLDA:   state_d = ST_HOLDB;
        ST_HOLDB: begin
          if (addl_q) begin
            state_d = dec_state;
            try_inc = retry;
            addl_en = 1'b1;
          end else begin
            state_d = ST_VSET;
          end
        end
        ST_VSET:    state_d = ST_VDUM;
        ST_VDUM:    state_d = ST_VSETTLE;
        ST_VSETTLE: state_d = ST_VREAD;
        ST_VREAD: begin
          state_d = ST_VEXIT;
          miss_en = 1'b1;
        end
        ST_VEXIT: begin
          addl_en = 1'b1;
          if (try_short) begin
            state_d = ST_LOAD;
            addl_d  = 1'b1;
          end else begin
            state_d = dec_state;
            try_inc = retry;
          end
        end
        ST_ENDW:    state_d = ST_DONE;
        ST_FAILW:   state_d = ST_FAIL;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  // dwell time of the state about to be entered
  always_comb begin
    case (state_d)
      ST_SWEW:    dur = CW'(X_CYC);
      ST_SETUP:   dur = CW'(Y_CYC);
      ST_PULSE:   dur = width;
      ST_HOLDA:   dur = CW'(A_CYC);
      ST_HOLDB:   dur = CW'(B_CYC);
      ST_VSET:    dur = CW'(G_CYC);
      ST_VSETTLE: dur = CW'(E_CYC);
      ST_VEXIT:   dur = CW'(H_CYC);
      ST_ENDW,
      ST_FAILW:   dur = CW'(T_CYC);
      default:    dur = CW'(1);
    endcase
    tmr_val  = dur - CW'(1);
    tmr_load = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addl_q <= 1'b0;
    else if (addl_en) addl_q <= addl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) miss_q <= 1'b0;
    else if (miss_en) miss_q <= mismatch_i;
  end

  // Moore output decode
  always_comb begin
    swe_o      = !(state_q inside {ST_IDLE, ST_ENDW, ST_DONE, ST_FAILW, ST_FAIL});
    psu_o      = state_q inside {ST_SETUP, ST_PULSE, ST_HOLDA};
    prg_o      = (state_q == ST_PULSE);
    pv_o       = state_q inside {ST_VSET, ST_VDUM, ST_VSETTLE, ST_VREAD};
    wdt_en_o   = state_q inside {ST_WDT, ST_SETUP, ST_PULSE, ST_HOLDA, ST_HOLDB};
    load_o     = (state_q == ST_LOAD);
    addl_o     = addl_q && (state_q inside {ST_LOAD, ST_WDT, ST_SETUP, ST_PULSE, ST_HOLDA, ST_HOLDB});
    dummy_wr_o = (state_q == ST_VDUM);
    vread_o    = (state_q == ST_VREAD);
    done_o     = (state_q == ST_DONE);
    fail_o     = (state_q == ST_FAIL);
  end
endmodule

// File: rtl/fpv_seq_chk.sv
module fpv_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic swe_o,
  input logic psu_o,
  input logic prg_o,
  input logic pv_o,
  input logic wdt_en_o,
  input logic load_o,
  input logic dummy_wr_o,
  input logic vread_o,
  input logic done_o,
  input logic fail_o
);
  p_prg_inside_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prg_o |-> (psu_o && wdt_en_o));

  p_setup_before_prg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prg_o) |-> $past(psu_o));

  p_dummy_in_verify_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dummy_wr_o || vread_o) |-> (pv_o && !psu_o));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_fail_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> !fail_o);

  p_end_without_swe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fail_o) |-> (!swe_o && !(done_o && fail_o)));

  p_no_restart_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fail_o) |=> !swe_o);

  p_wdt_scope_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_en_o |-> (swe_o && !pv_o && !load_o));
endmodule

bind fpv_seq fpv_seq_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .swe_o      (swe_o),
  .psu_o      (psu_o),
  .prg_o      (prg_o),
  .pv_o       (pv_o),
  .wdt_en_o   (wdt_en_o),
  .load_o     (load_o),
  .dummy_wr_o (dummy_wr_o),
  .vread_o    (vread_o),
  .done_o     (done_o),
  .fail_o     (fail_o)
);

// File: tb/fpv_seq_tb_top.sv
module fpv_seq_tb_top;
  localparam int X = 3, Y = 2, Z1 = 4, Z2 = 6, Z3 = 2, A = 2, B = 3;
  localparam int G = 2, E = 3, H = 2, T = 4, SHORT = 2, MAXT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic mismatch_i = 1'b0;
  logic swe_o, psu_o, prg_o, pv_o, wdt_en_o, load_o, addl_o, dummy_wr_o, vread_o, done_o, fail_o;

  always #2.5 clk = ~clk;

  fpv_seq #(.X_CYC(X), .Y_CYC(Y), .Z1_CYC(Z1), .Z2_CYC(Z2), .Z3_CYC(Z3), .A_CYC(A),
            .B_CYC(B), .G_CYC(G), .E_CYC(E), .H_CYC(H), .T_CYC(T),
            .SHORT_TRY(SHORT), .MAX_TRY(MAXT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mismatch_i(mismatch_i),
    .swe_o(swe_o), .psu_o(psu_o), .prg_o(prg_o), .pv_o(pv_o), .wdt_en_o(wdt_en_o),
    .load_o(load_o), .addl_o(addl_o), .dummy_wr_o(dummy_wr_o), .vread_o(vread_o),
    .done_o(done_o), .fail_o(fail_o)
  );

  typedef struct {
    logic [10:0] vec;
    int          dur;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int k_fail = 0;
  int reads_done = 0;
  bit finished = 1'b0;

  function automatic logic [10:0] mk(bit swe, bit psu, bit prg, bit pv, bit wdt, bit ld,
                                     bit ad, bit dw, bit vr, bit dn, bit fl);
    return {swe, psu, prg, pv, wdt, ld, ad, dw, vr, dn, fl};
  endfunction

  task automatic push(logic [10:0] v, int d, string r);
    item_t it;
    it.vec = v; it.dur = d; it.req = r;
    q.push_back(it);
  endtask

  task automatic push_pass(int n, bit a);
    int w;
    w = a ? Z3 : ((n <= SHORT) ? Z1 : Z2);
    push(mk(1,0,0,0,0,1,a,0,0,0,0), 1, a ? "R6" : "R2");
    push(mk(1,0,0,0,1,0,a,0,0,0,0), 1, "R10");
    push(mk(1,1,0,0,1,0,a,0,0,0,0), Y, "R2");
    push(mk(1,1,1,0,1,0,a,0,0,0,0), w, a ? "R6" : "R3");
    push(mk(1,1,0,0,1,0,a,0,0,0,0), A, "R2");
    push(mk(1,0,0,0,1,0,a,0,0,0,0), B, "R10");
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  // k: number of verify reads answered with a mismatch
  task automatic run_op(int k, bit mid_start, bit end_start);
    bit miss;
    k_fail = k;
    reads_done = 0;
    push(mk(0,0,0,0,0,0,0,0,0,0,0), 0, "R9");
    push(mk(1,0,0,0,0,0,0,0,0,0,0), X, "R1");
    for (int n = 1; n <= MAXT; n++) begin
      push_pass(n, 1'b0);
      push(mk(1,0,0,1,0,0,0,0,0,0,0), G, "R4");
      push(mk(1,0,0,1,0,0,0,1,0,0,0), 1, "R4");
      push(mk(1,0,0,1,0,0,0,0,0,0,0), E, "R4");
      push(mk(1,0,0,1,0,0,0,0,1,0,0), 1, "R4");
      push(mk(1,0,0,0,0,0,0,0,0,0,0), H, "R5");
      miss = (n <= k);
      if (n <= SHORT) push_pass(n, 1'b1);
      if (!miss) begin
        push(mk(0,0,0,0,0,0,0,0,0,0,0), T, "R7");
        push(mk(0,0,0,0,0,0,0,0,0,1,0), 1, "R7");
        break;
      end
      if (n == MAXT) begin
        push(mk(0,0,0,0,0,0,0,0,0,0,0), T, "R8");
        push(mk(0,0,0,0,0,0,0,0,0,0,1), 1, "R8");
      end
    end
    pulse_start();
    if (mid_start) begin
      repeat (8) @(negedge clk);
      pulse_start();
    end
    forever begin
      @(negedge clk);
      if (done_o || fail_o) break;
    end
    if (end_start) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (6) @(negedge clk);
    check(q.size() == 0, "R9", "timeline items left", q.size(), 0);
    check(swe_o == 1'b0, "R9", "swe after end", int'(swe_o), 0);
  endtask

  // verify answer from the data engine
  initial begin
    forever begin
      @(negedge clk);
      mismatch_i = (reads_done < k_fail);
      if (vread_o) reads_done++;
    end
  end

  // monitor: close each output segment and compare with the expected timeline
  initial begin
    logic [10:0] prev, cur;
    int cyc, seg_start;
    item_t it;
    prev = '0; cyc = 0; seg_start = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      cyc++;
      cur = {swe_o, psu_o, prg_o, pv_o, wdt_en_o, load_o, addl_o, dummy_wr_o, vread_o, done_o, fail_o};
      if (cur !== prev) begin
        if (q.size() == 0) begin
          check(1'b0, "R9", "unexpected output change", int'(cur), int'(prev));
        end else begin
          it = q.pop_front();
          check(it.vec == prev, it.req, "segment outputs", int'(prev), int'(it.vec));
          if (it.dur != 0)
            check((cyc - seg_start) == it.dur, it.req, "segment length", cyc - seg_start, it.dur);
        end
        seg_start = cyc;
        prev = cur;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({swe_o, psu_o, prg_o, pv_o, wdt_en_o, load_o, addl_o, dummy_wr_o, vread_o, done_o, fail_o} == '0,
          "R1", "reset outputs", int'({swe_o, psu_o, prg_o, pv_o, wdt_en_o, load_o, addl_o, dummy_wr_o, vread_o, done_o, fail_o}), 0);
    run_op(0, 1'b0, 1'b1);   // first verify passes, done coincides with start
    run_op(3, 1'b0, 1'b0);   // long pulses after early attempts, then pass
    run_op(10, 1'b1, 1'b1);  // never passes: fail at attempt limit
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule